// File: doc/BRIEF.md
# Strobed Three-Wire Configuration Port

This block receives configuration frames from an external controller over three wires: a serial data line, a serial clock and an active-low strobe. While the strobe is held low, each rising edge of the serial clock captures one data bit, most significant bit first. A frame is 19 bits long. The bit that arrives last (D0) is the word select: 0 addresses configuration word 0, 1 addresses word 1. The other 18 bits (D18 first, down to D1) are the payload. A frame is written into the selected word only when the strobe returns high, and only if exactly 19 clock edges were seen. A frame of any other length is dropped.

Word 0 carries the settings of the two output bridges: two 6-bit current codes, two direction bits, two decay-mode bits, a reference selector and a range selector. Word 1 carries the timing settings: blank time, fixed off time, fast-decay time, oscillator selection, synchronous-rectifier mode, two reserved bits and the idle control. All fields are brought out decoded.

Holding the sleep input low, or raising the undervoltage input, returns both words to their reset values. In the reset state every bit is 0 except the most significant off-time bit, which is 1, so the off time starts at a safe length. The serial lines are brought into the system clock domain through a synchronizer. A state machine with the states ST_IDLE, ST_SHIFT and ST_OVER tracks each frame:

- ST_IDLE goes to ST_SHIFT when the strobe is low.
- ST_SHIFT goes to ST_IDLE on a strobe rise, committing the frame if the count is 19.
- ST_SHIFT goes to ST_OVER on a 20th clock edge.
- ST_OVER goes to ST_IDLE on a strobe rise, with no commit.
- A sleep or undervoltage clear forces ST_IDLE from any state.

Top module: `stepper_cfg_port`

## Requirements
- R1: After reset, both words are in their reset state: every field reads 0, except off_time, which reads 16 (the off-time MSB set), and idle_mode, which reads 1.
- R2: A 19-bit frame whose last bit (D0) is 0 writes D18..D1 into word 0 and leaves word 1 unchanged.
- R3: A 19-bit frame whose last bit (D0) is 1 writes D18..D1 into word 1 and leaves word 0 unchanged.
- R4: Word 0 field positions:
    - br1_code = D6..D1
    - br2_code = D12..D7
    - br1_dir = D13
    - br2_dir = D14
    - br1_slow = D15
    - br2_slow = D16
    - ref_ext = D17
    - range_div4 = D18
- R5: Word 1 field positions:
    - blank_sel = D2..D1
    - off_time = D7..D3
    - fast_time = D11..D8
    - osc_sel = D13..D12
    - sr_mode = D15..D14
    - rsvd_bits = D17..D16
    - idle_mode = NOT D18 (D18 = 0 means idle)
- R6: Outputs do not change while the strobe is low, even after all 19 bits have arrived. The update appears only after the strobe returns high.
- R7: A frame with fewer than 19 clock edges, including a strobe pulse with no edges at all, is discarded.
- R8: A frame with more than 19 clock edges is discarded.
- R9: While sleep_n is low, both words are held at their reset state, and frames sent during that time are not retained.
- R10: While uv_fault is high, both words are held at their reset state.
- R11: Serial clock edges while the strobe is high change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_strobe | input | 1 | Frame strobe, active low, idles high |
| sleep_n | input | 1 | Sleep request, active low; clears both words |
| uv_fault | input | 1 | Undervoltage indication; clears both words |
| br1_code | output | 6 | Bridge 1 current code |
| br2_code | output | 6 | Bridge 2 current code |
| br1_dir | output | 1 | Bridge 1 current direction |
| br2_dir | output | 1 | Bridge 2 current direction |
| br1_slow | output | 1 | Bridge 1 decay: 1 slow, 0 mixed |
| br2_slow | output | 1 | Bridge 2 decay: 1 slow, 0 mixed |
| ref_ext | output | 1 | 1 selects the external reference |
| range_div4 | output | 1 | 1 selects divide-by-4 scaling, 0 divide-by-8 |
| blank_sel | output | 2 | Blank time selection |
| off_time | output | 5 | Fixed off-time count |
| fast_time | output | 4 | Fast-decay portion count |
| osc_sel | output | 2 | Oscillator source and divider selection |
| sr_mode | output | 2 | Synchronous-rectifier mode |
| rsvd_bits | output | 2 | Reserved bits, passed through |
| idle_mode | output | 1 | 1 when the idle bit was written 0 |

## Verification
The hardest case to reach is a frame that is complete inside the shift register but must not yet be visible. The bench lowers the strobe, clocks all 19 bits, and then waits with the strobe still low before it compares the outputs with the previous word. Only after that does it raise the strobe and look for the new value.

The length-filter states are reached with frames of 18 and 20 edges. The 20-edge frame carries a valid-looking word in its last 19 bits, so a design that kept only the newest 19 bits would accept it.

The sleep case sends a full, valid frame while sleep_n is low. It then releases sleep and checks that the reset state survives.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int FRAME_BITS = 19;
    localparam int DATA_BITS  = FRAME_BITS - 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_OVER  = 2'd2
    } shift_state_e;

    localparam logic [DATA_BITS-1:0] WORD0_RST = '0;
    // off-time MSB (D7, payload index 6) forced high
    localparam logic [DATA_BITS-1:0] WORD1_RST = DATA_BITS'(1) << 6;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign lvl = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_fsm.sv
module cfg_shift_fsm
    import cfg_port_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb_lvl,
    input  logic             stb_rise,
    input  logic             sclk_rise,
    input  logic             sdata,
    output logic             wr_en,
    output logic             wr_sel,
    output logic [NBITS-2:0] wr_data
);
    localparam int CW = $clog2(NBITS + 1);
    localparam logic [CW-1:0] FULL = CW'(NBITS);

    shift_state_e state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [NBITS-1:0] sr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!stb_lvl) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (stb_rise)                         state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == FULL)  state_d = ST_OVER;
            end
            ST_OVER:  if (stb_rise) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (clr || state_q == ST_IDLE) begin
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT && sclk_rise && !stb_rise && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
            sr_q  <= {sr_q[NBITS-2:0], sdata};
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            ST_SHIFT: wr_en = stb_rise && (cnt_q == FULL) && !clr;
            ST_IDLE, ST_OVER: wr_en = 1'b0;
            default: wr_en = 1'b0;
        endcase
    end

    assign wr_sel  = sr_q[0];
    assign wr_data = sr_q[NBITS-1:1];
endmodule

// File: rtl/cfg_word_regs.sv
module cfg_word_regs
    import cfg_port_pkg::*;
#(
    parameter int DBITS = DATA_BITS,
    parameter logic [DBITS-1:0] RST0 = WORD0_RST,
    parameter logic [DBITS-1:0] RST1 = WORD1_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DBITS-1:0] wr_data,
    output logic [DBITS-1:0] word0,
    output logic [DBITS-1:0] word1
);
    localparam logic [1:0][DBITS-1:0] RSTV = {RST1, RST0};
    logic [1:0][DBITS-1:0] word_q;

    for (genvar g = 0; g < 2; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                word_q[g] <= RSTV[g];
            else if (clr)                              word_q[g] <= RSTV[g];
            else if (wr_en && (wr_sel == 1'(g)))       word_q[g] <= wr_data;
        end
    end

    assign word0 = word_q[0];
    assign word1 = word_q[1];
endmodule

// File: rtl/stepper_cfg_port.sv
module stepper_cfg_port
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_data,
    input  logic       ser_clk,
    input  logic       ser_strobe,
    input  logic       sleep_n,
    input  logic       uv_fault,
    output logic [5:0] br1_code,
    output logic [5:0] br2_code,
    output logic       br1_dir,
    output logic       br2_dir,
    output logic       br1_slow,
    output logic       br2_slow,
    output logic       ref_ext,
    output logic       range_div4,
    output logic [1:0] blank_sel,
    output logic [4:0] off_time,
    output logic [3:0] fast_time,
    output logic [1:0] osc_sel,
    output logic [1:0] sr_mode,
    output logic [1:0] rsvd_bits,
    output logic       idle_mode
);
    logic [2:0] sync_lvl;
    logic [1:0] edge_q;
    logic       stb_rise, sclk_rise, clr;
    logic       wr_en, wr_sel;
    logic [DATA_BITS-1:0] wr_data, w0_q, w1_q;

    assign clr = !sleep_n || uv_fault;

    // bit 0 strobe (idles high), bit 1 serial clock, bit 2 data
    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .din({ser_data, ser_clk, ser_strobe}),
        .lvl(sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= 2'b01;
        else        edge_q <= sync_lvl[1:0];
    end

    assign stb_rise  = sync_lvl[0] & ~edge_q[0];
    assign sclk_rise = sync_lvl[1] & ~edge_q[1];

    cfg_shift_fsm #(.NBITS(FRAME_BITS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .stb_lvl(sync_lvl[0]), .stb_rise(stb_rise),
        .sclk_rise(sclk_rise), .sdata(sync_lvl[2]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    cfg_word_regs #(.DBITS(DATA_BITS)) regs_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .word0(w0_q), .word1(w1_q)
    );

    // word 0 decode (payload index = D number - 1)
    assign br1_code   = w0_q[5:0];
    assign br2_code   = w0_q[11:6];
    assign br1_dir    = w0_q[12];
    assign br2_dir    = w0_q[13];
    assign br1_slow   = w0_q[14];
    assign br2_slow   = w0_q[15];
    assign ref_ext    = w0_q[16];
    assign range_div4 = w0_q[17];

    // word 1 decode
    assign blank_sel  = w1_q[1:0];
    assign off_time   = w1_q[6:2];
    assign fast_time  = w1_q[10:7];
    assign osc_sel    = w1_q[12:11];
    assign sr_mode    = w1_q[14:13];
    assign rsvd_bits  = w1_q[16:15];
    assign idle_mode  = ~w1_q[17];
endmodule

// File: rtl/stepper_cfg_port_chk.sv
module stepper_cfg_port_chk
    import cfg_port_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_n,
    input logic                 uv_fault,
    input logic                 stb_rise,
    input logic                 wr_en,
    input logic                 wr_sel,
    input logic [DATA_BITS-1:0] w0,
    input logic [DATA_BITS-1:0] w1
);
    // R9
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> (w0 == WORD0_RST && w1 == WORD1_RST));

    // R10
    uv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_fault |=> (w0 == WORD0_RST && w1 == WORD1_RST));

    // R6
    hold_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && sleep_n && !uv_fault) |=> ($stable(w0) && $stable(w1)));

    // R6
    commit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> stb_rise);

    // R2
    w0_write_keeps_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && sleep_n && !uv_fault) |=> $stable(w1));

    // R3
    w1_write_keeps_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && sleep_n && !uv_fault) |=> $stable(w0));
endmodule

bind stepper_cfg_port stepper_cfg_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uv_fault(uv_fault),
    .stb_rise(stb_rise), .wr_en(wr_en), .wr_sel(wr_sel),
    .w0(w0_q), .w1(w1_q)
);

// File: tb/stepper_cfg_port_tb_top.sv
module stepper_cfg_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_strobe = 1'b1;
    logic sleep_n = 1'b1, uv_fault = 1'b0;
    logic [5:0] br1_code, br2_code;
    logic br1_dir, br2_dir, br1_slow, br2_slow, ref_ext, range_div4, idle_mode;
    logic [1:0] blank_sel, osc_sel, sr_mode, rsvd_bits;
    logic [4:0] off_time;
    logic [3:0] fast_time;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [17:0] RST0 = 18'h00000;
    localparam logic [17:0] RST1 = 18'h00040;
    // range=0 ref=1 slow2=1 slow1=0 dir2=0 dir1=1 br2=13 br1=2D
    localparam logic [17:0] V0 = {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h13, 6'h2D};
    // d18=1 rsvd=00 sr=10 osc=11 fast=9 off=0B blank=10
    localparam logic [17:0] V1 = {1'b1, 2'b00, 2'b10, 2'b11, 4'h9, 5'h0B, 2'b10};
    localparam logic [17:0] V0B = 18'h15A5A;

    always #4 clk = ~clk;

    stepper_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_strobe(ser_strobe), .sleep_n(sleep_n), .uv_fault(uv_fault),
        .br1_code(br1_code), .br2_code(br2_code), .br1_dir(br1_dir), .br2_dir(br2_dir),
        .br1_slow(br1_slow), .br2_slow(br2_slow), .ref_ext(ref_ext), .range_div4(range_div4),
        .blank_sel(blank_sel), .off_time(off_time), .fast_time(fast_time), .osc_sel(osc_sel),
        .sr_mode(sr_mode), .rsvd_bits(rsvd_bits), .idle_mode(idle_mode)
    );

    function automatic logic [17:0] rd_w0();
        return {range_div4, ref_ext, br2_slow, br1_slow, br2_dir, br1_dir, br2_code, br1_code};
    endfunction

    function automatic logic [17:0] rd_w1();
        return {~idle_mode, rsvd_bits, sr_mode, osc_sel, fast_time, off_time, blank_sel};
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        @(negedge clk) ser_data = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic stb_low();
        @(negedge clk) ser_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic stb_high();
        repeat (4) @(negedge clk);
        ser_strobe = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [19:0] bits, input int n);
        stb_low();
        for (int i = n - 1; i >= 0; i--) ser_bit(bits[i]);
        stb_high();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 word0", rd_w0(), RST0);
        check("R1 word1", rd_w1(), RST1);
        check("R1 off_time", 18'(off_time), 18'd16);
        check("R1 idle_mode", 18'(idle_mode), 18'd1);
    endtask

    task automatic t_word0();
        send({1'b0, V0, 1'b0}, 19);
        check("R2 word0", rd_w0(), V0);
        check("R2 word1 kept", rd_w1(), RST1);
        check("R4 br1_code", 18'(br1_code), 18'h2D);
        check("R4 br2_code", 18'(br2_code), 18'h13);
        check("R4 bits", 18'({range_div4, ref_ext, br2_slow, br1_slow, br2_dir, br1_dir}), 18'b011001);
    endtask

    task automatic t_word1();
        send({1'b0, V1, 1'b1}, 19);
        check("R3 word1", rd_w1(), V1);
        check("R3 word0 kept", rd_w0(), V0);
        check("R5 blank_sel", 18'(blank_sel), 18'd2);
        check("R5 off_time", 18'(off_time), 18'h0B);
        check("R5 fast_time", 18'(fast_time), 18'h9);
        check("R5 osc_sel", 18'(osc_sel), 18'd3);
        check("R5 sr_mode", 18'(sr_mode), 18'd2);
        check("R5 idle_mode", 18'(idle_mode), 18'd0);
    endtask

    task automatic t_hold();
        logic [18:0] fr = {V0B, 1'b0};
        stb_low();
        for (int i = 18; i >= 0; i--) ser_bit(fr[i]);
        repeat (20) @(negedge clk);
        check("R6 held while strobe low", rd_w0(), V0);
        stb_high();
        check("R6 commit after strobe rise", rd_w0(), V0B);
    endtask

    task automatic t_short();
        send({2'b00, 18'h3FFFF}, 18);
        check("R7 18-bit frame dropped w0", rd_w0(), V0B);
        check("R7 18-bit frame dropped w1", rd_w1(), V1);
        send(20'h0, 0);
        check("R7 empty strobe dropped", rd_w0(), V0B);
    endtask

    task automatic t_long();
        send({1'b1, V0, 1'b0}, 20);
        check("R8 20-bit frame dropped", rd_w0(), V0B);
    endtask

    task automatic t_idle_clk();
        for (int i = 0; i < 6; i++) ser_bit(1'b1);
        repeat (8) @(negedge clk);
        check("R11 clocks with strobe high w0", rd_w0(), V0B);
        check("R11 clocks with strobe high w1", rd_w1(), V1);
    endtask

    task automatic t_sleep();
        @(negedge clk) sleep_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 sleep clears w0", rd_w0(), RST0);
        check("R9 sleep clears w1", rd_w1(), RST1);
        send({1'b0, V0, 1'b0}, 19);
        @(negedge clk) sleep_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R9 write in sleep not kept", rd_w0(), RST0);
        send({1'b0, V0, 1'b0}, 19);
        check("R9 writes resume after sleep", rd_w0(), V0);
    endtask

    task automatic t_uv();
        send({1'b0, V1, 1'b1}, 19);
        @(negedge clk) uv_fault = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 uv clears w0", rd_w0(), RST0);
        check("R10 uv clears w1", rd_w1(), RST1);
        @(negedge clk) uv_fault = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 stays reset after uv", rd_w1(), RST1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_word0();
        t_word1();
        t_hold();
        t_short();
        t_long();
        t_idle_clk();
        t_sleep();
        t_uv();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule